// File: doc/BRIEF.md
# Serial Configuration Stream Loader

This block lets a slow host configure a front-end readout chip over a four-wire SPI link. The host sends fixed 32-bit frames. Each frame names one of a small set of registers: a control word, a read-only status word, a bank of mask words, and a stream port. A write to the stream port carries a 3-bit pin vector plus an active-low enable. The loader copies that vector onto the chip's serial configuration pins: reset, shift clock and serial data. The host toggles the shift clock one vector at a time, so it builds the whole configuration sequence itself.

While the stream plays out, the loader counts the rising edges it produces on the shift-clock pin. It compares that count with the fixed configuration length of 538 bits and reports the outcome in the status word. A done flag says the length was reached exactly, and an overflow flag says the host sent too many clocks. A vector that asserts the reset pin starts a fresh load. Reads use a two-frame scheme. A read frame selects a register, and the value comes back on MISO during the next frame.

Top module: `cfgStreamLoader`

## Requirements
- R1: After reset, feRst, feClk, feData and spiMiso are 0, and the status and control words read back as zero.
- R2: A frame is exactly 32 bits, sampled on rising spiSclk edges while spiCsN is low, most significant bit first. Bit 31 is 1 for a read. Bits 30:28 are the register code (0 control, 1 status, 2 mask, 3 stream). Bits 27:20 are the index and bits 19:0 the data. If spiCsN rises before the 32nd bit, the frame is dropped and has no effect.
- R3: During the frame after a read frame, spiMiso carries the selected 32-bit value, MSB first. It moves to the next bit after each falling spiSclk edge. The frame after any non-read frame returns all zeros.
- R4: A control write stores data bits 19:0. A mask write stores data bits 19:0 into the mask word chosen by the index (4 words). Reads return the stored value zero-extended. A mask access whose index is 4 or higher writes nothing and reads zero.
- R5: A stream write applies its vector when data bit 3 (enable, active low) is 0 and control bit 0 is 1. Bit 2 then goes to feRst, bit 1 to feClk and bit 0 to feData.
- R6: A stream write is ignored when its enable bit is 1 or when control bit 0 is 0. The pins and the bit count are unchanged.
- R7: The status bit count (status bits 9:0) rises by one for each applied vector that takes feClk from 0 to 1 with reset 0. Any other vector leaves the count unchanged.
- R8: Status bit 16 (done) sets when the count reaches 538. It stays set until a reset vector.
- R9: Status bit 17 (overflow) sets when a clock edge arrives while the count is already 538 or more.
- R10: An applied vector with bit 2 set clears the count, done and overflow, and is not counted as an edge.
- R11: Writes to the status code are ignored.
- R12: Writes to codes 4 to 7 are ignored, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | SPI clock from host, idle low |
| spiCsN | input | 1 | SPI chip select, active low |
| spiMosi | input | 1 | SPI data from host |
| spiMiso | output | 1 | SPI reply data to host |
| feRst | output | 1 | Front-end configuration reset pin |
| feClk | output | 1 | Front-end configuration shift clock pin |
| feData | output | 1 | Front-end configuration serial data pin |

## Verification
The SPI inputs pass through a two-stage synchronizer and an edge detector, so every effect lags the host edge that caused it. A frame takes effect about three to four system cycles after its 32nd rising SPI clock edge. This covers the register writes, the pin vector and the count. The bench waits through the chip-select deassertion and a further gap before it checks any pin or sends the status read. The MISO bit moves about three system cycles after a falling SPI clock edge, so reads run with a half period of six system cycles and sample MISO just before each rising edge. Bulk stream frames use a shorter half period because their replies are never inspected.

// File: rtl/cfgStreamPkg.sv
`timescale 1ns/1ps
package cfgStreamPkg;
  localparam int FRAME_W  = 32;
  localparam int DATA_W   = 20;
  localparam int IDX_W    = 8;
  localparam int RW_POS   = 31;
  localparam int CODE_LSB = 28;
  localparam int IDX_LSB  = 20;
  localparam int DONE_POS = 16;
  localparam int OVF_POS  = 17;
  localparam int EN_POS   = 3;
  localparam int RST_POS  = 2;
  localparam int CLK_POS  = 1;
  localparam int DAT_POS  = 0;

  typedef enum logic [2:0] {
    CODE_CTRL   = 3'd0,
    CODE_STATUS = 3'd1,
    CODE_MASK   = 3'd2,
    CODE_STREAM = 3'd3
  } regCode_e;

  typedef struct packed {
    logic sample;
    logic commit;
    logic shiftOut;
  } spiStrobe_t;
endpackage

// File: rtl/cfgSyncChain.sv
`timescale 1ns/1ps
module cfgSyncChain #(
  parameter int STAGES = 2,
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (STAGES <= 1) begin : gSingle
      logic [WIDTH-1:0] stageQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= RST_VAL;
        else       stageQ <= din;
      end
      assign dout = stageQ;
    end else begin : gMulti
      logic [STAGES-1:0][WIDTH-1:0] pipeQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipeQ <= {STAGES{RST_VAL}};
        else       pipeQ <= {pipeQ[STAGES-2:0], din};
      end
      assign dout = pipeQ[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cfgStreamCtrl.sv
`timescale 1ns/1ps
module cfgStreamCtrl
  import cfgStreamPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiSclk,
  input  logic       spiCsN,
  input  logic       spiMosi,
  output spiStrobe_t strobe,
  output logic       mosiBit
);
  localparam int FCNT_W = $clog2(FRAME_W + 1);
  localparam logic [FCNT_W-1:0] FULL = FCNT_W'(FRAME_W);
  localparam logic [FCNT_W-1:0] LAST = FCNT_W'(FRAME_W - 1);

  logic [2:0] syncBus;
  logic csNS, sclkS, sclkPrev;
  logic sclkRise, sclkFall;
  logic [FCNT_W-1:0] frameCnt;

  cfgSyncChain #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b100)
  ) uSync (
    .clk (clk),
    .rstN(rstN),
    .din ({spiCsN, spiSclk, spiMosi}),
    .dout(syncBus)
  );

  assign csNS    = syncBus[2];
  assign sclkS   = syncBus[1];
  assign mosiBit = syncBus[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkS;
  end

  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            frameCnt <= '0;
    else if (csNS)                        frameCnt <= '0;
    else if (sclkRise && frameCnt < FULL) frameCnt <= frameCnt + 1'b1;
  end

  always_comb begin
    strobe.sample   = !csNS && sclkRise && (frameCnt < FULL);
    strobe.commit   = strobe.sample && (frameCnt == LAST);
    strobe.shiftOut = !csNS && sclkFall && (frameCnt != '0) && (frameCnt < FULL);
  end
endmodule

// File: rtl/cfgStreamDatapath.sv
`timescale 1ns/1ps
module cfgStreamDatapath
  import cfgStreamPkg::*;
#(
  parameter int CFG_BITS   = 538,
  parameter int MASK_WORDS = 4,
  parameter int CNT_W      = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  spiStrobe_t       strobe,
  input  logic             mosiBit,
  output logic             spiMiso,
  output logic             feRst,
  output logic             feClk,
  output logic             feData,
  output logic [CNT_W-1:0] bitCount,
  output logic             doneFlag,
  output logic             ovfFlag
);
  localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(CFG_BITS);
  localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(CFG_BITS - 1);

  logic [FRAME_W-2:0] rxShift;
  logic [FRAME_W-1:0] word;
  logic               isRead;
  logic [2:0]         code;
  logic [IDX_W-1:0]   index;
  logic [DATA_W-1:0]  wdata;
  logic [DATA_W-1:0]  ctrlReg;
  logic [MASK_WORDS-1:0][DATA_W-1:0] maskReg;
  logic [DATA_W-1:0]  maskRead;
  logic [FRAME_W-1:0] statusWord, readData, replyReg;
  logic writeHit, applyVec, resetVec, clkRiseVec;

  assign word   = {rxShift, mosiBit};
  assign isRead = word[RW_POS];
  assign code   = word[CODE_LSB +: 3];
  assign index  = word[IDX_LSB +: IDX_W];
  assign wdata  = word[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rxShift <= '0;
    else if (strobe.sample) rxShift <= word[FRAME_W-2:0];
  end

  assign writeHit = strobe.commit && !isRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (writeHit && code == CODE_CTRL) ctrlReg <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskReg <= '0;
    else if (writeHit && code == CODE_MASK) begin
      for (int w = 0; w < MASK_WORDS; w++) begin
        if (index == IDX_W'(w)) maskReg[w] <= wdata;
      end
    end
  end

  always_comb begin
    maskRead = '0;
    for (int w = 0; w < MASK_WORDS; w++) begin
      if (index == IDX_W'(w)) maskRead = maskReg[w];
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[CNT_W-1:0] = bitCount;
    statusWord[DONE_POS]  = doneFlag;
    statusWord[OVF_POS]   = ovfFlag;
  end

  always_comb begin
    case (code)
      CODE_CTRL:   readData = FRAME_W'(ctrlReg);
      CODE_STATUS: readData = statusWord;
      CODE_MASK:   readData = FRAME_W'(maskRead);
      default:     readData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                replyReg <= '0;
    else if (strobe.commit)   replyReg <= isRead ? readData : '0;
    else if (strobe.shiftOut) replyReg <= {replyReg[FRAME_W-2:0], 1'b0};
  end

  assign spiMiso = replyReg[FRAME_W-1];

  assign applyVec   = writeHit && (code == CODE_STREAM) && !wdata[EN_POS] && ctrlReg[0];
  assign resetVec   = applyVec && wdata[RST_POS];
  assign clkRiseVec = applyVec && !wdata[RST_POS] && wdata[CLK_POS] && !feClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      feRst  <= 1'b0;
      feClk  <= 1'b0;
      feData <= 1'b0;
    end else if (applyVec) begin
      feRst  <= wdata[RST_POS];
      feClk  <= wdata[CLK_POS];
      feData <= wdata[DAT_POS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      doneFlag <= 1'b0;
      ovfFlag  <= 1'b0;
    end else if (resetVec) begin
      bitCount <= '0;
      doneFlag <= 1'b0;
      ovfFlag  <= 1'b0;
    end else if (clkRiseVec) begin
      if (bitCount != '1)       bitCount <= bitCount + 1'b1;
      if (bitCount == LIMIT_M1) doneFlag <= 1'b1;
      if (bitCount >= LIMIT)    ovfFlag  <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgStreamLoader.sv
`timescale 1ns/1ps
module cfgStreamLoader
  import cfgStreamPkg::*;
#(
  parameter int CFG_BITS    = 538,
  parameter int MASK_WORDS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiSclk,
  input  logic spiCsN,
  input  logic spiMosi,
  output logic spiMiso,
  output logic feRst,
  output logic feClk,
  output logic feData
);
  localparam int CNT_W = $clog2(CFG_BITS + 1);

  spiStrobe_t       strobe;
  logic             mosiBit;
  logic [CNT_W-1:0] bitCount;
  logic             doneFlag, ovfFlag;

  cfgStreamCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .spiSclk(spiSclk),
    .spiCsN (spiCsN),
    .spiMosi(spiMosi),
    .strobe (strobe),
    .mosiBit(mosiBit)
  );

  cfgStreamDatapath #(
    .CFG_BITS  (CFG_BITS),
    .MASK_WORDS(MASK_WORDS),
    .CNT_W     (CNT_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .mosiBit (mosiBit),
    .spiMiso (spiMiso),
    .feRst   (feRst),
    .feClk   (feClk),
    .feData  (feData),
    .bitCount(bitCount),
    .doneFlag(doneFlag),
    .ovfFlag (ovfFlag)
  );
endmodule

// File: rtl/cfgStreamLoaderChk.sv
`timescale 1ns/1ps
module cfgStreamLoaderChk #(
  parameter int CFG_BITS = 538,
  parameter int CNT_W    = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             feRst,
  input logic             feClk,
  input logic [CNT_W-1:0] bitCount,
  input logic             doneFlag,
  input logic             ovfFlag
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CFG_BITS);

  p_count_on_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bitCount != $past(bitCount) && bitCount != '0)
      |-> ($rose(feClk) && bitCount == CNT_W'($past(bitCount) + 1'b1)));

  p_done_at_limit_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> (bitCount == LIMIT));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneFlag) |-> feRst);

  p_ovf_needs_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> doneFlag);

  p_reset_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    feRst |-> (bitCount == '0 && !doneFlag && !ovfFlag));
endmodule

bind cfgStreamLoader cfgStreamLoaderChk #(
  .CFG_BITS(CFG_BITS),
  .CNT_W   (CNT_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .feRst   (feRst),
  .feClk   (feClk),
  .bitCount(bitCount),
  .doneFlag(doneFlag),
  .ovfFlag (ovfFlag)
);

// File: tb/cfgStreamLoader_test.sv
`timescale 1ns/1ps
module cfgStreamLoader_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0;
  logic spiCsN = 1'b1;
  logic spiMosi = 1'b0;
  logic spiMiso, feRst, feClk, feData;
  int checks = 0;
  int errors = 0;
  int hp = 6;

  always #2.5 clk = ~clk;

  cfgStreamLoader uut (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .feRst(feRst), .feClk(feClk), .feData(feData)
  );

  function automatic logic [31:0] mk(input logic rd, input logic [2:0] code,
                                     input logic [7:0] idx, input logic [19:0] data);
    return {rd, code, idx, data};
  endfunction

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic spiXfer(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
    rx = '0;
    @(negedge clk);
    spiCsN = 1'b0;
    repeat (hp) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spiMosi = tx[31-i];
      repeat (hp) @(negedge clk);
      rx = {rx[30:0], spiMiso};
      spiSclk = 1'b1;
      repeat (hp) @(negedge clk);
      spiSclk = 1'b0;
    end
    repeat (hp) @(negedge clk);
    spiCsN = 1'b1;
    spiMosi = 1'b0;
    repeat (hp + 2) @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] code, input logic [7:0] idx, input logic [19:0] data);
    logic [31:0] rx;
    spiXfer(mk(1'b0, code, idx, data), 32, rx);
  endtask

  task automatic regRead(input logic [2:0] code, input logic [7:0] idx, output logic [31:0] val);
    logic [31:0] rx;
    spiXfer(mk(1'b1, code, idx, 20'h0), 32, rx);
    spiXfer(mk(1'b0, 3'd7, 8'h0, 20'h0), 32, val);
  endtask

  task automatic sendVec(input logic enN, input logic r, input logic c, input logic d);
    regWrite(3'd3, 8'h0, {16'h0, enN, r, c, d});
  endtask

  function automatic logic [31:0] stat(input int cnt, input logic done, input logic ovf);
    return (32'(ovf) << 17) | (32'(done) << 16) | 32'(cnt);
  endfunction

  task automatic testReset;
    logic [31:0] v;
    checkVal("R1 pins", {29'h0, feRst, feClk, feData}, 32'h0);
    checkVal("R1 miso", {31'h0, spiMiso}, 32'h0);
    regRead(3'd1, 8'h0, v);
    checkVal("R1 status", v, 32'h0);
    regRead(3'd0, 8'h0, v);
    checkVal("R1 control", v, 32'h0);
  endtask

  task automatic testRegs;
    logic [31:0] v, rx;
    regWrite(3'd0, 8'h5A, 20'hABCD1);
    regRead(3'd0, 8'h0, v);
    checkVal("R4 control readback", v, 32'h000ABCD1);
    regWrite(3'd2, 8'd0, 20'h12345);
    regWrite(3'd2, 8'd3, 20'hFEDCB);
    regRead(3'd2, 8'd0, v);
    checkVal("R4 mask word 0", v, 32'h00012345);
    regRead(3'd2, 8'd3, v);
    checkVal("R4 mask word 3", v, 32'h000FEDCB);
    regWrite(3'd2, 8'd200, 20'h77777);
    regRead(3'd2, 8'd200, v);
    checkVal("R4 mask index out of range reads zero", v, 32'h0);
    regRead(3'd2, 8'd0, v);
    checkVal("R4 out of range write leaves word 0", v, 32'h00012345);
    spiXfer(mk(1'b0, 3'd0, 8'h0, 20'h55550), 16, rx);
    regRead(3'd0, 8'h0, v);
    checkVal("R2 short frame dropped", v, 32'h000ABCD1);
    regWrite(3'd0, 8'h0, 20'hABCD0);
    spiXfer(mk(1'b0, 3'd7, 8'h0, 20'h0), 32, rx);
    checkVal("R3 reply after write is zero", rx, 32'h0);
  endtask

  task automatic testIgnored;
    logic [31:0] v;
    sendVec(1'b0, 1'b0, 1'b1, 1'b1);
    checkVal("R6 stream disabled pins", {29'h0, feRst, feClk, feData}, 32'h0);
    regRead(3'd1, 8'h0, v);
    checkVal("R6 stream disabled count", v, 32'h0);
    regWrite(3'd1, 8'h0, 20'hFFFFF);
    regRead(3'd1, 8'h0, v);
    checkVal("R11 status write ignored", v, 32'h0);
    regWrite(3'd5, 8'h0, 20'h13579);
    regRead(3'd5, 8'h0, v);
    checkVal("R12 unused code reads zero", v, 32'h0);
    regWrite(3'd0, 8'h0, 20'h00001);
    sendVec(1'b1, 1'b0, 1'b1, 1'b1);
    checkVal("R6 enable high ignored", {29'h0, feRst, feClk, feData}, 32'h0);
  endtask

  task automatic testPins;
    logic [31:0] v;
    sendVec(1'b0, 1'b1, 1'b0, 1'b1);
    checkVal("R5 reset and data pins", {29'h0, feRst, feClk, feData}, 32'h5);
    sendVec(1'b0, 1'b0, 1'b0, 1'b0);
    checkVal("R5 pins low", {29'h0, feRst, feClk, feData}, 32'h0);
    sendVec(1'b0, 1'b0, 1'b1, 1'b1);
    checkVal("R5 clock and data pins", {29'h0, feRst, feClk, feData}, 32'h3);
    sendVec(1'b0, 1'b0, 1'b1, 1'b0);
    regRead(3'd1, 8'h0, v);
    checkVal("R7 one edge counted, held clock not counted", v, stat(1, 1'b0, 1'b0));
    sendVec(1'b0, 1'b1, 1'b0, 1'b0);
    sendVec(1'b0, 1'b1, 1'b1, 1'b0);
    regRead(3'd1, 8'h0, v);
    checkVal("R10 clock with reset not counted", v, 32'h0);
  endtask

  task automatic testFullLoad;
    logic [31:0] v;
    hp = 2;
    sendVec(1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 537; i++) begin
      sendVec(1'b0, 1'b0, 1'b0, 1'(i));
      sendVec(1'b0, 1'b0, 1'b1, 1'(i));
    end
    hp = 6;
    regRead(3'd1, 8'h0, v);
    checkVal("R8 one short of length", v, stat(537, 1'b0, 1'b0));
    sendVec(1'b0, 1'b0, 1'b0, 1'b1);
    sendVec(1'b0, 1'b0, 1'b1, 1'b1);
    regRead(3'd1, 8'h0, v);
    checkVal("R8 done at full length", v, stat(538, 1'b1, 1'b0));
    sendVec(1'b0, 1'b0, 1'b0, 1'b0);
    sendVec(1'b0, 1'b0, 1'b1, 1'b0);
    regRead(3'd1, 8'h0, v);
    checkVal("R9 overflow on extra edge", v, stat(539, 1'b1, 1'b1));
    sendVec(1'b0, 1'b1, 1'b0, 1'b0);
    regRead(3'd1, 8'h0, v);
    checkVal("R10 reset vector clears status", v, 32'h0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testRegs();
    testIgnored();
    testPins();
    testFullLoad();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule